// File: doc/BRIEF.md
# Host-Bus Chip-Select Decoder

This block sits in front of an external host-bus interface and decides which of four active-low chip-select lines a bus transaction drives. On each cycle with the request strobe high it compares the transaction address against the memory windows that are switched on, applies the single, dual or quad assignment rules, and registers the result. The strobe polarity, the wait-state count and the multiplexed/non-multiplexed interface setting for the chosen chip select are registered alongside it, ready for the bus timing engine.

Three two-bit window fields switch on the windows. The code field uses value 1 for a window at 0x1000_0000. The peripheral field uses 1 for 0xA000_0000 and 2 for 0xC000_0000. The RAM field uses 1 for 0x6000_0000 and 2 for 0x8000_0000. Value 0 switches a window off. Illegal combinations never reach a chip-select line. Instead they raise a registered configuration-error flag. Such combinations are a window claimed twice for one line, a field value that the mode does not allow, and a multiplexed target while address-latch enable is off.

Top module: `hb_cs_decoder`

## Requirements
- R1: While reset is asserted, `cs_n` is 4'b1111, `cfg_err` is 0, and `sel_mux`, `sel_wait` and `sel_strobe_pol` are 0.
- R2: Outputs change one clock after an edge at which `req_valid` is high. After an edge with `req_valid` low, `cs_n` is 4'b1111 while `cfg_err`, `sel_mux`, `sel_wait` and `sel_strobe_pol` keep their values.
- R3: At most one bit of `cs_n` is low at any time.
- R4: Quad mode is `cs_mode`=2'b10. It is legal only with `ram_win`=3, `perip_win`=3 and `code_win`=0; any other field setting sets `cfg_err`. In quad mode, addresses 0x6000_0000–0x7FFF_FFFF assert `cs_n[0]`, 0x8000_0000–0x9FFF_FFFF assert `cs_n[1]`, 0xA000_0000–0xBFFF_FFFF assert `cs_n[2]` and 0xC000_0000–0xDFFF_FFFF assert `cs_n[3]`.
- R5: Outside quad mode each enabled window spans 256 MB from its base. The field encodings give the bases, as listed above. An address outside every enabled window asserts no chip select. In dual mode with only the code window enabled, that window drives `cs_n[0]`.
- R6: In dual mode (`cs_mode`=2'b01) with two windows enabled, `cs_n[0]` takes the code window if it is on, and otherwise the peripheral window. `cs_n[1]` takes the remaining window.
- R7: In dual mode with only the peripheral window or only the RAM window enabled, address bit 27 splits that window. When bit 27 is 0, `cs_n[0]` asserts; when it is 1, `cs_n[1]` asserts.
- R8: In single mode (`cs_mode`=2'b00), only `cs_n[0]` is ever driven, and it asserts for the one enabled peripheral or RAM window. A nonzero `code_win` in single mode sets `cfg_err`.
- R9: With `per_cs_cfg`=0, the selected parameters are always those of chip select 0. These are bit 0 of `cs_mux`, bits 3:0 of `cs_wait` and bit 0 of `cs_strobe_pol`. With `per_cs_cfg`=1, they are the set of the asserted chip select, or set 0 when none asserts.
- R10: A decoded chip select whose selected `cs_mux` bit is 1 (multiplexed) while `ale_en` is 0 asserts nothing and sets `cfg_err`.
- R11: Each of the following sets `cfg_err` and asserts no chip select: `cs_mode`=2'b11; outside quad mode, a field value of 3 or a `code_win` of 2 or 3; all three windows enabled in dual mode; and peripheral plus RAM windows both enabled in single mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transaction-valid strobe |
| req_addr | input | 32 | Transaction address |
| cs_mode | input | 2 | 00 single, 01 dual, 10 quad, 11 reserved |
| code_win | input | 2 | Code window field |
| perip_win | input | 2 | Peripheral window field |
| ram_win | input | 2 | RAM window field |
| per_cs_cfg | input | 1 | 1: each chip select uses its own parameter set |
| ale_en | input | 1 | Address-latch enable available |
| cs_mux | input | 4 | Per-chip-select interface mode, 1 = multiplexed |
| cs_wait | input | 16 | Per-chip-select wait states, 4 bits each, CS0 in bits 3:0 |
| cs_strobe_pol | input | 4 | Per-chip-select strobe polarity |
| cs_n | output | 4 | Active-low chip selects |
| sel_mux | output | 1 | Selected interface mode |
| sel_wait | output | 4 | Selected wait-state count |
| sel_strobe_pol | output | 1 | Selected strobe polarity |
| cfg_err | output | 1 | Configuration error flag |

## Verification
The bench sweeps every mode and window-field combination against addresses that step through all 256 MB slices, with both values of bit 27. If the half-split were keyed on the wrong bit, a shared dual window would drive the wrong line. A wrong quad boundary would assert a line one slice early, or would assert one at 0xE000_0000. The bench also targets the error rules. A decoder that skipped the double-claim or field-value checks would drive two windows onto one line, or would answer to value 3 outside quad mode. One that ignored the latch-enable rule would drive a multiplexed target without address latching. Parameter selection is checked with both settings of the per-select bit and with distinct sets per line. Idle cycles between requests check that the chip selects release and that the parameters hold. A design that collapsed the wrong way would show another line's wait count.

// File: rtl/hb_cs_pkg.sv
package hb_cs_pkg;

  typedef enum logic [1:0] {
    CSM_SINGLE = 2'b00,
    CSM_DUAL   = 2'b01,
    CSM_QUAD   = 2'b10,
    CSM_RSVD   = 2'b11
  } cs_mode_e;

  // Top address nibble of each 256 MB window
  localparam logic [3:0] NIB_CODE    = 4'h1;
  localparam logic [3:0] NIB_RAM_LO  = 4'h6;
  localparam logic [3:0] NIB_RAM_HI  = 4'h8;
  localparam logic [3:0] NIB_PER_LO  = 4'hA;
  localparam logic [3:0] NIB_PER_HI  = 4'hC;

  // Top three address bits of the first 512 MB quad slice
  localparam logic [2:0] QUAD_BASE3  = 3'd3;

  typedef logic [1:0] win_field_t;

endpackage

// File: rtl/hb_cs_window.sv
module hb_cs_window
  import hb_cs_pkg::*;
#(
  parameter int NUM_CS = 4
) (
  input  logic [4:0]        addr_top,   // address bits [31:27]
  input  win_field_t        code_f,
  input  win_field_t        perip_f,
  input  win_field_t        ram_f,
  output logic              code_hit,
  output logic              perip_hit,
  output logic              ram_hit,
  output logic              half_sel,
  output logic [NUM_CS-1:0] quad_hit
);

  logic [3:0] nib;
  logic [3:0] perip_nib;
  logic [3:0] ram_nib;
  logic       perip_ok;
  logic       ram_ok;

  assign nib       = addr_top[4:1];
  assign half_sel  = addr_top[0];

  always_comb begin
    perip_ok  = (perip_f == 2'd1) || (perip_f == 2'd2);
    ram_ok    = (ram_f == 2'd1) || (ram_f == 2'd2);
    perip_nib = (perip_f == 2'd1) ? NIB_PER_LO : NIB_PER_HI;
    ram_nib   = (ram_f == 2'd1) ? NIB_RAM_LO : NIB_RAM_HI;
    code_hit  = (code_f == 2'd1) && (nib == NIB_CODE);
    perip_hit = perip_ok && (nib == perip_nib);
    ram_hit   = ram_ok && (nib == ram_nib);
  end

  // One 512 MB slice per chip select in quad mode
  for (genvar g = 0; g < NUM_CS; g++) begin : g_quad
    assign quad_hit[g] = (addr_top[4:2] == (QUAD_BASE3 + 3'(g)));
  end

endmodule

// File: rtl/hb_cs_assign.sv
module hb_cs_assign
  import hb_cs_pkg::*;
#(
  parameter int NUM_CS = 4
) (
  input  cs_mode_e          mode,
  input  win_field_t        code_f,
  input  win_field_t        perip_f,
  input  win_field_t        ram_f,
  input  logic              code_hit,
  input  logic              perip_hit,
  input  logic              ram_hit,
  input  logic              half_sel,
  input  logic [NUM_CS-1:0] quad_hit,
  output logic [NUM_CS-1:0] hit,
  output logic              map_err
);

  logic code_en;
  logic perip_en;
  logic ram_en;
  logic field_bad;
  logic any_win;

  always_comb begin
    code_en   = (code_f != 2'd0);
    perip_en  = (perip_f != 2'd0);
    ram_en    = (ram_f != 2'd0);
    field_bad = (code_f > 2'd1) || (perip_f == 2'd3) || (ram_f == 2'd3);
    any_win   = perip_hit || ram_hit;
    hit       = '0;
    map_err   = 1'b0;
    unique case (mode)
      CSM_SINGLE: begin
        map_err = field_bad || code_en || (perip_en && ram_en);
        if (!map_err) hit[0] = any_win;
      end
      CSM_DUAL: begin
        map_err = field_bad || (code_en && perip_en && ram_en);
        if (!map_err) begin
          if (code_en) begin
            hit[0] = code_hit;
            hit[1] = any_win;
          end else if (perip_en && ram_en) begin
            hit[0] = perip_hit;
            hit[1] = ram_hit;
          end else begin
            hit[0] = any_win && !half_sel;
            hit[1] = any_win && half_sel;
          end
        end
      end
      CSM_QUAD: begin
        map_err = !((code_f == 2'd0) && (perip_f == 2'd3) && (ram_f == 2'd3));
        if (!map_err) hit = quad_hit;
      end
      default: map_err = 1'b1;
    endcase
  end

endmodule

// File: rtl/hb_cs_param_sel.sv
module hb_cs_param_sel #(
  parameter int NUM_CS = 4,
  parameter int WAIT_W = 4
) (
  input  logic [NUM_CS-1:0]        hit_in,
  input  logic                     per_cs,
  input  logic                     ale_en,
  input  logic [NUM_CS-1:0]        if_mux,
  input  logic [NUM_CS*WAIT_W-1:0] wait_in,
  input  logic [NUM_CS-1:0]        pol_in,
  output logic [NUM_CS-1:0]        hit_out,
  output logic                     sel_mux,
  output logic [WAIT_W-1:0]        sel_wait,
  output logic                     sel_pol,
  output logic                     ale_err
);

  localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] eff;

  always_comb begin
    idx = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (hit_in[i]) idx = IDX_W'(i);
    end
  end

  always_comb begin
    eff      = per_cs ? idx : '0;
    sel_mux  = if_mux[eff];
    sel_wait = wait_in[eff*WAIT_W +: WAIT_W];
    sel_pol  = pol_in[eff];
    ale_err  = (|hit_in) && sel_mux && !ale_en;
    hit_out  = ale_err ? '0 : hit_in;
  end

endmodule

// File: rtl/hb_cs_decoder.sv
module hb_cs_decoder
  import hb_cs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NUM_CS = 4,
  parameter int WAIT_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [1:0]               cs_mode,
  input  logic [1:0]               code_win,
  input  logic [1:0]               perip_win,
  input  logic [1:0]               ram_win,
  input  logic                     per_cs_cfg,
  input  logic                     ale_en,
  input  logic [NUM_CS-1:0]        cs_mux,
  input  logic [NUM_CS*WAIT_W-1:0] cs_wait,
  input  logic [NUM_CS-1:0]        cs_strobe_pol,
  output logic [NUM_CS-1:0]        cs_n,
  output logic                     sel_mux,
  output logic [WAIT_W-1:0]        sel_wait,
  output logic                     sel_strobe_pol,
  output logic                     cfg_err
);

  localparam int TOP_W = 5;

  // Reset synchronizer: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [TOP_W-1:0]  addr_top;
  logic              unused_addr_low;
  logic              code_hit, perip_hit, ram_hit, half_sel;
  logic [NUM_CS-1:0] quad_hit;
  logic [NUM_CS-1:0] map_hit;
  logic              map_err;
  logic [NUM_CS-1:0] fin_hit;
  logic              mux_c;
  logic [WAIT_W-1:0] wait_c;
  logic              pol_c;
  logic              ale_err;

  assign addr_top        = req_addr[ADDR_W-1 -: TOP_W];
  assign unused_addr_low = ^req_addr[ADDR_W-TOP_W-1:0];

  hb_cs_window #(.NUM_CS(NUM_CS)) u_window (
    .addr_top  (addr_top),
    .code_f    (code_win),
    .perip_f   (perip_win),
    .ram_f     (ram_win),
    .code_hit  (code_hit),
    .perip_hit (perip_hit),
    .ram_hit   (ram_hit),
    .half_sel  (half_sel),
    .quad_hit  (quad_hit)
  );

  hb_cs_assign #(.NUM_CS(NUM_CS)) u_assign (
    .mode      (cs_mode_e'(cs_mode)),
    .code_f    (code_win),
    .perip_f   (perip_win),
    .ram_f     (ram_win),
    .code_hit  (code_hit),
    .perip_hit (perip_hit),
    .ram_hit   (ram_hit),
    .half_sel  (half_sel),
    .quad_hit  (quad_hit),
    .hit       (map_hit),
    .map_err   (map_err)
  );

  hb_cs_param_sel #(.NUM_CS(NUM_CS), .WAIT_W(WAIT_W)) u_param (
    .hit_in   (map_hit),
    .per_cs   (per_cs_cfg),
    .ale_en   (ale_en),
    .if_mux   (cs_mux),
    .wait_in  (cs_wait),
    .pol_in   (cs_strobe_pol),
    .hit_out  (fin_hit),
    .sel_mux  (mux_c),
    .sel_wait (wait_c),
    .sel_pol  (pol_c),
    .ale_err  (ale_err)
  );

  // Next-state logic
  logic [NUM_CS-1:0] cs_n_q, cs_n_d;
  logic              err_q, err_d;
  logic              mux_q, mux_d;
  logic [WAIT_W-1:0] wait_q, wait_d;
  logic              pol_q, pol_d;
  logic              upd_en;

  assign upd_en = req_valid;

  always_comb begin
    cs_n_d = '1;
    err_d  = err_q;
    mux_d  = mux_q;
    wait_d = wait_q;
    pol_d  = pol_q;
    if (upd_en) begin
      cs_n_d = ~fin_hit;
      err_d  = map_err || ale_err;
      mux_d  = mux_c;
      wait_d = wait_c;
      pol_d  = pol_c;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cs_n_q <= '1;
    end else begin
      cs_n_q <= cs_n_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      err_q  <= 1'b0;
      mux_q  <= 1'b0;
      wait_q <= '0;
      pol_q  <= 1'b0;
    end else if (upd_en) begin
      err_q  <= err_d;
      mux_q  <= mux_d;
      wait_q <= wait_d;
      pol_q  <= pol_d;
    end
  end

  assign cs_n           = cs_n_q;
  assign cfg_err        = err_q;
  assign sel_mux        = mux_q;
  assign sel_wait       = wait_q;
  assign sel_strobe_pol = pol_q;

  // Assertions
  assert_cs_onehot_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0(~cs_n));

  assert_idle_release_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    !req_valid |=> (cs_n == '1));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    !req_valid |=> ($stable(cfg_err) && $stable(sel_wait) && $stable(sel_mux)));

  assert_err_suppress_R11: assert property (@(posedge clk) disable iff (!rst_int_n)
    cfg_err |-> (cs_n == '1));

  assert_single_cs0_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_valid && cs_mode == 2'b00) |=> (cs_n[NUM_CS-1:1] == '1));

  assert_mux_needs_ale_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    req_valid |=> !((cs_n != '1) && sel_mux && !$past(ale_en)));

  assert_collapse_cs0_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_valid && !per_cs_cfg) |=> (sel_wait == $past(cs_wait[WAIT_W-1:0])));

endmodule

// File: tb/hb_cs_decoder_bench.sv
`timescale 1ns/1ps
module hb_cs_decoder_bench;

  localparam int NCS = 4;
  localparam int WW  = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic [31:0]   req_addr;
  logic [1:0]    cs_mode, code_win, perip_win, ram_win;
  logic          per_cs_cfg, ale_en;
  logic [3:0]    cs_mux;
  logic [15:0]   cs_wait;
  logic [3:0]    cs_strobe_pol;
  logic [3:0]    cs_n;
  logic          sel_mux, sel_strobe_pol, cfg_err;
  logic [3:0]    sel_wait;

  always #2.5 clk = ~clk;

  hb_cs_decoder u_hb_cs_decoder (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .cs_mode(cs_mode), .code_win(code_win), .perip_win(perip_win), .ram_win(ram_win),
    .per_cs_cfg(per_cs_cfg), .ale_en(ale_en), .cs_mux(cs_mux), .cs_wait(cs_wait),
    .cs_strobe_pol(cs_strobe_pol), .cs_n(cs_n), .sel_mux(sel_mux), .sel_wait(sel_wait),
    .sel_strobe_pol(sel_strobe_pol), .cfg_err(cfg_err)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  string tag_now  = "R1";
  string tag_chk  = "R1";

  // Reference state
  logic [3:0] e_cs_n = 4'hF;
  logic       e_err = 1'b0, e_mux = 1'b0, e_pol = 1'b0;
  logic [3:0] e_wait = 4'h0;

  function automatic bit in_win(longint ua, longint base);
    return (ua >= base) && (ua < base + 64'h1000_0000);
  endfunction

  function automatic void ref_decode(input logic [31:0] a, input int m, input int c,
                                     input int p, input int r, output int idx, output bit err);
    longint ua;
    bit inc, inp, inr;
    ua = longint'(a);
    idx = -1;
    err = 0;
    if (m == 3) err = 1;
    else if (m == 2) begin
      if (!(c == 0 && p == 3 && r == 3)) err = 1;
      else if (ua >= 64'h6000_0000 && ua < 64'hE000_0000)
        idx = int'((ua - 64'h6000_0000) / 64'h2000_0000);
    end else begin
      if (c > 1 || p == 3 || r == 3) err = 1;
      if (m == 0 && (c != 0 || (p != 0 && r != 0))) err = 1;
      if (m == 1 && c != 0 && p != 0 && r != 0) err = 1;
      if (!err) begin
        inc = (c == 1) && in_win(ua, 64'h1000_0000);
        inp = (p != 0) && in_win(ua, (p == 1) ? 64'hA000_0000 : 64'hC000_0000);
        inr = (r != 0) && in_win(ua, (r == 1) ? 64'h6000_0000 : 64'h8000_0000);
        if (m == 0) idx = (inp || inr) ? 0 : -1;
        else if (c != 0) idx = inc ? 0 : ((inp || inr) ? 1 : -1);
        else if (p != 0 && r != 0) idx = inp ? 0 : (inr ? 1 : -1);
        else if (inp || inr) idx = ((ua % 64'h1000_0000) >= 64'h0800_0000) ? 1 : 0;
      end
    end
  endfunction

  always @(posedge clk or negedge rst_n) begin
    int idx, e;
    bit err;
    if (!rst_n) begin
      e_cs_n <= 4'hF; e_err <= 0; e_mux <= 0; e_wait <= 0; e_pol <= 0;
    end else if (req_valid) begin
      ref_decode(req_addr, int'(cs_mode), int'(code_win), int'(perip_win), int'(ram_win), idx, err);
      e = (per_cs_cfg && idx >= 0) ? idx : 0;
      if (idx >= 0 && cs_mux[e] && !ale_en) begin
        err = 1;
        idx = -1;
      end
      e_cs_n <= (idx >= 0) ? ~(4'b1 << idx) : 4'hF;
      e_err  <= err;
      e_mux  <= cs_mux[e];
      e_wait <= cs_wait[e*WW +: WW];
      e_pol  <= cs_strobe_pol[e];
    end else begin
      e_cs_n <= 4'hF;
    end
  end

  task automatic check_outputs(input string tag);
    int zeros;
    n_checks++;
    if (cs_n !== e_cs_n || cfg_err !== e_err || sel_mux !== e_mux ||
        sel_wait !== e_wait || sel_strobe_pol !== e_pol) begin
      n_fail++;
      $display("FAIL %s: got cs_n=%b err=%b mux=%b wait=%h pol=%b, expected cs_n=%b err=%b mux=%b wait=%h pol=%b",
               tag, cs_n, cfg_err, sel_mux, sel_wait, sel_strobe_pol,
               e_cs_n, e_err, e_mux, e_wait, e_pol);
    end
    zeros = 0;
    for (int i = 0; i < NCS; i++) if (cs_n[i] === 1'b0) zeros++;
    n_checks++;
    if (zeros > 1) begin
      n_fail++;
      $display("FAIL R3: got %0d chip selects low (cs_n=%b), expected at most 1", zeros, cs_n);
    end
  endtask

  // Check the previous cycle's result, then apply new stimulus
  task automatic step(input logic v, input logic [31:0] a, input string tag);
    @(negedge clk);
    check_outputs(tag_chk);
    req_valid = v;
    req_addr  = a;
    tag_chk   = tag;
  endtask

  function automatic string classify(int m, int c, int p, int r);
    if (m == 3) return "R11";
    if (m == 2) return "R4";
    if (c > 1 || p == 3 || r == 3) return "R11";
    if (m == 0) return (c != 0) ? "R8" : ((p != 0 && r != 0) ? "R11" : "R8");
    if (c != 0 && p != 0 && r != 0) return "R11";
    if ((c != 0) + (p != 0) + (r != 0) == 2) return "R6";
    if (c == 0 && (p != 0 || r != 0)) return "R7";
    return "R5";
  endfunction

  initial begin
    rst_n = 1'b0; req_valid = 0; req_addr = 0; cs_mode = 0; code_win = 0;
    perip_win = 0; ram_win = 0; per_cs_cfg = 0; ale_en = 1; cs_mux = 0;
    cs_wait = 16'hD963; cs_strobe_pol = 4'b1010;
    repeat (3) @(negedge clk);
    // R1: reset state
    n_checks++;
    if (cs_n !== 4'hF || cfg_err !== 1'b0 || sel_mux !== 1'b0 || sel_wait !== 4'h0 || sel_strobe_pol !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: got cs_n=%b err=%b mux=%b wait=%h pol=%b, expected 1111/0/0/0/0",
               cs_n, cfg_err, sel_mux, sel_wait, sel_strobe_pol);
    end
    rst_n = 1'b1;
    tag_chk = "R1";
    repeat (5) step(1'b0, 32'h0, "R1");

    // Full sweep of mode and window fields against all 128 MB slices
    for (int m = 0; m < 4; m++)
      for (int c = 0; c < 4; c++)
        for (int p = 0; p < 4; p++)
          for (int r = 0; r < 4; r++) begin
            @(negedge clk);
            check_outputs(tag_chk);
            cs_mode = 2'(m); code_win = 2'(c); perip_win = 2'(p); ram_win = 2'(r);
            req_valid = 0;
            tag_chk = "R2";
            for (int k = 0; k < 32; k++)
              step(1'b1, (32'(k) << 27) | 32'h0012_3450, classify(m, c, p, r));
          end

    // Parameter selection and latch-enable rule in quad and dual modes
    for (int cfg = 0; cfg < 2; cfg++)
      for (int pc = 0; pc < 2; pc++)
        for (int al = 0; al < 2; al++)
          for (int mp = 0; mp < 4; mp++) begin
            @(negedge clk);
            check_outputs(tag_chk);
            req_valid = 0;
            tag_chk = "R2";
            if (cfg == 0) begin cs_mode = 2'b10; code_win = 0; perip_win = 3; ram_win = 3; end
            else          begin cs_mode = 2'b01; code_win = 0; perip_win = 1; ram_win = 2; end
            per_cs_cfg = pc[0];
            ale_en     = al[0];
            cs_mux     = (mp == 0) ? 4'b0000 : (mp == 1) ? 4'b0001 : (mp == 2) ? 4'b0100 : 4'b1010;
            cs_strobe_pol = 4'b0110 ^ 4'(mp);
            for (int k = 0; k < 32; k++) begin
              step(1'b1, (32'(k) << 27) | 32'h0000_0ABC, al ? "R9" : "R10");
              if (k % 3 == 2) step(1'b0, 32'hFFFF_FFFF, "R2");
            end
          end

    step(1'b0, 32'h0, "R2");
    step(1'b0, 32'h0, "R2");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got %0d cycles, expected completion", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule